// File: doc/BRIEF.md
# Sliding-Surface Duty Cycle Calculator

This block computes the duty cycle for one switching period of a step-down converter. It takes an output-voltage sample and an inductor-current sample, forms a sliding-surface offset and two predicted surface slopes (switch on and switch off), and solves the zero-average condition for a raw duty. It then blends the raw duty with a fixed steady-state duty using an integer weight N, and clamps the result to a 10-bit word. All plant and gain coefficients come in already computed, in the accumulator's own fixed-point units. The block only does the arithmetic; deriving the coefficients and driving the switch are done elsewhere.

A sample enters through a valid/ready handshake. `smp_ready` is high only while the block is idle. A sample is taken on any clock edge where `smp_valid` and `smp_ready` are both high. While the block is busy, `smp_valid` has no effect: the block applies back-pressure and the sender must hold off. An accepted sample is stored and is used by the *next* calculation. The calculation started by this handshake uses the sample stored at the previous handshake, so the control law sees a one-period delay.

The result has no back-pressure. `duty_done` pulses for one clock when `duty` takes its new value. `duty` then keeps that value until the next pulse. The coefficient, offset, `d_star` and `n_blend` inputs must stay stable from acceptance until `duty_done`.

Top module: `slide_duty_calc`

## Requirements
- R1: During and right after reset, `smp_ready` is 1, `duty` is 0 and `duty_done` is 0. The stored samples are zero, so the first calculation uses x1 = x2 = 0.
- R2: A sample is accepted only when `smp_valid` and `smp_ready` are both high. After an acceptance, `smp_ready` stays low until the cycle in which `duty_done` pulses. `smp_valid` has no effect while `smp_ready` is low.
- R3: The calculation started at acceptance k uses the voltage and current captured at acceptance k−1.
- R4: With x1, x2 the delayed samples taken as unsigned integers:
  - s = k_sv·x1 + k_si·x2 − ofs_ref
  - on = k_onv·x1 + k_oni·x2 + ofs_on
  - off = k_offv·x1 + k_offi·x2 + ofs_off
  
  The coefficients are signed 16-bit and the offsets are signed 32-bit. The sampling period is already folded into the slope terms.
- R5: With num = 2·s + off and den = off − on, and den > 0, the raw duty is num·1024/den truncated toward zero. Duty codes use 1024 as 1.0.
- R6: If den ≤ 0, blending is skipped and `duty` becomes 1023 when num > 0 and 0 otherwise.
- R7: The blended value is (raw + N·d*)/(N+1) truncated toward zero, where N = `n_blend` (0 to 31) and d* = `d_star`.
- R8: A blended value ≤ 0 gives `duty` = 0. A blended value above 1023 gives `duty` = 1023.
- R9: `duty_done` is high for exactly one clock per calculation. `duty` changes only on the edge that raises `duty_done`.
- R10: `duty_done` rises no more than 104 clocks after acceptance (with the default widths). A sample offered in the `duty_done` cycle is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Block idle, sample can be taken |
| smp_v | input | 12 | Output-voltage sample x1 |
| smp_i | input | 12 | Inductor-current sample x2 |
| k_sv | input | 16 | Surface gain on x1, signed |
| k_si | input | 16 | Surface gain on x2, signed |
| k_onv | input | 16 | On-slope gain on x1, signed |
| k_oni | input | 16 | On-slope gain on x2, signed |
| k_offv | input | 16 | Off-slope gain on x1, signed |
| k_offi | input | 16 | Off-slope gain on x2, signed |
| ofs_ref | input | 32 | Reference subtracted from the surface, signed |
| ofs_on | input | 32 | Source term of the on slope, signed |
| ofs_off | input | 32 | Source term of the off slope, signed |
| d_star | input | 10 | Steady-state duty code |
| n_blend | input | 5 | Blending weight N |
| duty | output | 10 | Saturated duty code |
| duty_done | output | 1 | One-clock pulse: new duty valid |

## Verification
Two events can land in the same clock: the `duty_done` pulse that delivers one result, and the acceptance of the next sample. The bench provokes this by offering the next sample at the very clock edge where it sees the pulse. For that cycle it checks the delivered word. It also checks that the following result is computed from the sample accepted one transaction earlier, not from the one just taken. Samples offered while the block is busy are used as a second probe: the next result reveals whether a busy-time offer slipped into the sample store.

// File: rtl/dcalc_pkg.sv
`timescale 1ns/1ps
package dcalc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAC,
    ST_QRAW,
    ST_QMIX
  } calc_st_e;

  function automatic int unsigned wmax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dcalc_mac.sv
`timescale 1ns/1ps
module dcalc_mac #(
  parameter int X_W    = 12,
  parameter int COEF_W = 16,
  parameter int OFS_W  = 32,
  parameter int ACC_W  = OFS_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [X_W-1:0]           x_v,
  input  logic [X_W-1:0]           x_i,
  input  logic [6*COEF_W-1:0]      coefs,
  input  logic signed [OFS_W-1:0]  ofs_ref,
  input  logic signed [OFS_W-1:0]  ofs_on,
  input  logic signed [OFS_W-1:0]  ofs_off,
  output logic signed [ACC_W-1:0]  acc_s,
  output logic signed [ACC_W-1:0]  acc_on,
  output logic signed [ACC_W-1:0]  acc_off,
  output logic                     done
);

  localparam int P_W = COEF_W + X_W + 1;
  localparam int LAST = 5;

  logic [2:0]              step;
  logic                    busy;
  logic [COEF_W-1:0]       coef_sel;
  logic [X_W-1:0]          x_sel;
  logic signed [P_W-1:0]   prod;
  logic signed [ACC_W-1:0] prod_x;

  assign coef_sel = coefs[int'(step)*COEF_W +: COEF_W];
  assign x_sel    = step[0] ? x_i : x_v;
  assign prod     = $signed(coef_sel) * $signed({1'b0, x_sel});
  assign prod_x   = {{(ACC_W-P_W){prod[P_W-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        step <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (step == 3'(LAST)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 3'd1;
        end
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_acc
    logic signed [ACC_W-1:0] init_v;
    logic signed [ACC_W-1:0] acc_r;
    if (g == 0) begin : g_init_s
      assign init_v = -{{(ACC_W-OFS_W){ofs_ref[OFS_W-1]}}, ofs_ref};
    end else if (g == 1) begin : g_init_on
      assign init_v = {{(ACC_W-OFS_W){ofs_on[OFS_W-1]}}, ofs_on};
    end else begin : g_init_off
      assign init_v = {{(ACC_W-OFS_W){ofs_off[OFS_W-1]}}, ofs_off};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               acc_r <= '0;
      else if (start)                           acc_r <= init_v;
      else if (busy && (step[2:1] == 2'(g)))    acc_r <= acc_r + prod_x;
    end
  end

  assign acc_s   = g_acc[0].acc_r;
  assign acc_on  = g_acc[1].acc_r;
  assign acc_off = g_acc[2].acc_r;

  a_r4_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step <= 3'(LAST)));

endmodule

// File: rtl/dcalc_divu.sv
`timescale 1ns/1ps
module dcalc_divu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quo,
  output logic         done
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, d_r, r_r, dvd_r;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [W:0]    shifted, trial;

  assign shifted = {r_r, q_r[W-1]};
  assign trial   = shifted - {1'b0, d_r};
  assign quo     = q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0; d_r <= '0; r_r <= '0; dvd_r <= '0;
      cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r   <= dvd;
        d_r   <= dvs;
        dvd_r <= dvd;
        r_r   <= '0;
        cnt   <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (!trial[W]) begin
          r_r <= trial[W-1:0];
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= shifted[W-1:0];
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r5_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (d_r != '0)) |->
      ((({{W{1'b0}}, q_r} * {{W{1'b0}}, d_r}) + {{W{1'b0}}, r_r}) == {{W{1'b0}}, dvd_r})
      && (r_r < d_r));

endmodule

// File: rtl/dcalc_clip.sv
`timescale 1ns/1ps
module dcalc_clip #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  a,
  output logic [OUT_W-1:0] y
);

  localparam logic [IN_W-1:0] LIM = {{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

  assign y = (a > LIM) ? {OUT_W{1'b1}} : a[OUT_W-1:0];

endmodule

// File: rtl/slide_duty_calc.sv
`timescale 1ns/1ps
module slide_duty_calc
  import dcalc_pkg::*;
#(
  parameter int X_W    = 12,
  parameter int COEF_W = 16,
  parameter int OFS_W  = 32,
  parameter int DUTY_W = 10,
  parameter int N_W    = 5,
  parameter int RAW_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  output logic                     smp_ready,
  input  logic [X_W-1:0]           smp_v,
  input  logic [X_W-1:0]           smp_i,
  input  logic signed [COEF_W-1:0] k_sv,
  input  logic signed [COEF_W-1:0] k_si,
  input  logic signed [COEF_W-1:0] k_onv,
  input  logic signed [COEF_W-1:0] k_oni,
  input  logic signed [COEF_W-1:0] k_offv,
  input  logic signed [COEF_W-1:0] k_offi,
  input  logic signed [OFS_W-1:0]  ofs_ref,
  input  logic signed [OFS_W-1:0]  ofs_on,
  input  logic signed [OFS_W-1:0]  ofs_off,
  input  logic [DUTY_W-1:0]        d_star,
  input  logic [N_W-1:0]           n_blend,
  output logic [DUTY_W-1:0]        duty,
  output logic                     duty_done
);

  localparam int ACC_W = OFS_W + 2;
  localparam int NUM_W = ACC_W + 2;
  localparam int DEN_W = ACC_W + 1;
  localparam int DIV_W = NUM_W + DUTY_W;
  localparam int PND_W = N_W + DUTY_W;
  localparam int MIX_W = int'(wmax(RAW_W - 1, PND_W)) + 2;

  calc_st_e st;
  logic [X_W-1:0] hold_v, hold_i, work_v, work_i;
  logic           accept;

  logic signed [ACC_W-1:0] acc_s, acc_on, acc_off;
  logic                    mac_done;

  logic signed [NUM_W-1:0] num;
  logic signed [DEN_W-1:0] den;
  logic [NUM_W-1:0]        num_mag;
  logic                    num_pos, den_pos, neg_q;

  logic             dv_start;
  logic [DIV_W-1:0] dv_dvd, dv_dvs, dv_quo;
  logic             dv_done;

  logic [RAW_W-2:0]        raw_mag;
  logic signed [MIX_W-1:0] raw_s, mix;
  logic [PND_W-1:0]        prod_nd;
  logic [N_W:0]            n_p1;
  logic                    mix_pos;
  logic [DUTY_W-1:0]       duty_fin;

  logic [DUTY_W-1:0] duty_q;
  logic              done_q;

  assign smp_ready = (st == ST_IDLE);
  assign accept    = smp_valid && smp_ready;

  dcalc_mac #(.X_W(X_W), .COEF_W(COEF_W), .OFS_W(OFS_W), .ACC_W(ACC_W)) i_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .x_v     (work_v),
    .x_i     (work_i),
    .coefs   ({k_offi, k_offv, k_oni, k_onv, k_si, k_sv}),
    .ofs_ref (ofs_ref),
    .ofs_on  (ofs_on),
    .ofs_off (ofs_off),
    .acc_s   (acc_s),
    .acc_on  (acc_on),
    .acc_off (acc_off),
    .done    (mac_done)
  );

  assign num = $signed({acc_s[ACC_W-1], acc_s, 1'b0})
             + $signed({{2{acc_off[ACC_W-1]}}, acc_off});
  assign den = $signed({acc_off[ACC_W-1], acc_off})
             - $signed({acc_on[ACC_W-1], acc_on});
  assign num_mag = num[NUM_W-1] ? (~num + 1'b1) : num;
  assign num_pos = !num[NUM_W-1] && (num != '0);
  assign den_pos = !den[DEN_W-1] && (den != '0);

  // raw duty from the first quotient, then blending sum
  dcalc_clip #(.IN_W(DIV_W), .OUT_W(RAW_W-1)) i_clip_raw (
    .a (dv_quo),
    .y (raw_mag)
  );
  assign raw_s   = neg_q ? -$signed({{(MIX_W-RAW_W+1){1'b0}}, raw_mag})
                         :  $signed({{(MIX_W-RAW_W+1){1'b0}}, raw_mag});
  assign prod_nd = PND_W'(n_blend) * PND_W'(d_star);
  assign mix     = raw_s + $signed({{(MIX_W-PND_W){1'b0}}, prod_nd});
  assign mix_pos = !mix[MIX_W-1] && (mix != '0);
  assign n_p1    = {1'b0, n_blend} + (N_W+1)'(1);

  dcalc_clip #(.IN_W(DIV_W), .OUT_W(DUTY_W)) i_clip_out (
    .a (dv_quo),
    .y (duty_fin)
  );

  always_comb begin
    dv_start = 1'b0;
    dv_dvd   = '0;
    dv_dvs   = '0;
    if (st == ST_MAC && mac_done && den_pos) begin
      dv_start = 1'b1;
      dv_dvd   = {num_mag, {DUTY_W{1'b0}}};
      dv_dvs   = {{(DIV_W-ACC_W){1'b0}}, den[ACC_W-1:0]};
    end else if (st == ST_QRAW && dv_done && mix_pos) begin
      dv_start = 1'b1;
      dv_dvd   = {{(DIV_W-MIX_W){1'b0}}, mix};
      dv_dvs   = {{(DIV_W-N_W-1){1'b0}}, n_p1};
    end
  end

  dcalc_divu #(.W(DIV_W)) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dv_start),
    .dvd   (dv_dvd),
    .dvs   (dv_dvs),
    .quo   (dv_quo),
    .done  (dv_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      hold_v <= '0; hold_i <= '0;
      work_v <= '0; work_i <= '0;
      neg_q  <= 1'b0;
      duty_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          hold_v <= smp_v;  hold_i <= smp_i;
          work_v <= hold_v; work_i <= hold_i;
          st     <= ST_MAC;
        end
        ST_MAC: if (mac_done) begin
          if (den_pos) begin
            neg_q <= num[NUM_W-1];
            st    <= ST_QRAW;
          end else begin
            duty_q <= num_pos ? {DUTY_W{1'b1}} : '0;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        ST_QRAW: if (dv_done) begin
          if (mix_pos) begin
            st <= ST_QMIX;
          end else begin
            duty_q <= '0;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        ST_QMIX: if (dv_done) begin
          duty_q <= duty_fin;
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign duty      = duty_q;
  assign duty_done = done_q;

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    duty_done |=> !duty_done);

  a_r9_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_done |-> $stable(duty));

  a_r6_nonpos_den: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MAC && mac_done && !den_pos) |=>
      (duty_done && ((duty == '0) || (duty == {DUTY_W{1'b1}}))));

endmodule

// File: tb/test_slide_duty_calc.sv
`timescale 1ns/1ps
module test_slide_duty_calc;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [11:0] smp_v = '0, smp_i = '0;
  logic signed [15:0] k_sv = '0, k_si = '0, k_onv = '0, k_oni = '0, k_offv = '0, k_offi = '0;
  logic signed [31:0] ofs_ref = '0, ofs_on = '0, ofs_off = '0;
  logic [9:0] d_star = '0;
  logic [4:0] n_blend = '0;
  logic [9:0] duty;
  logic duty_done;

  int total = 0;
  int bad = 0;
  int prev_v = 0;
  int prev_i = 0;

  always #5 clk = ~clk;

  slide_duty_calc i_slide_duty_calc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_v(smp_v), .smp_i(smp_i),
    .k_sv(k_sv), .k_si(k_si), .k_onv(k_onv), .k_oni(k_oni),
    .k_offv(k_offv), .k_offi(k_offi),
    .ofs_ref(ofs_ref), .ofs_on(ofs_on), .ofs_off(ofs_off),
    .d_star(d_star), .n_blend(n_blend), .duty(duty), .duty_done(duty_done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint calc_exp(input int xv, input int xi);
    longint s, on, off, num, den, q, mix;
    s   = longint'(k_sv) * xv + longint'(k_si) * xi - longint'(ofs_ref);
    on  = longint'(k_onv) * xv + longint'(k_oni) * xi + longint'(ofs_on);
    off = longint'(k_offv) * xv + longint'(k_offi) * xi + longint'(ofs_off);
    num = 2 * s + off;
    den = off - on;
    if (den <= 0) return (num > 0) ? 1023 : 0;
    q = (num * 1024) / den;
    if (q > 32767) q = 32767;
    if (q < -32767) q = -32767;
    mix = q + longint'(n_blend) * longint'(d_star);
    if (mix <= 0) return 0;
    q = mix / (longint'(n_blend) + 1);
    return (q > 1023) ? 1023 : q;
  endfunction

  function automatic int rs(input int bits);
    return int'($urandom_range(0, (1 << bits) - 1)) - (1 << (bits - 1));
  endfunction

  // called at a falling edge with the block idle
  task automatic xact(input logic [11:0] v, input logic [11:0] i, input string tag,
                      input bit poke, input bit gap);
    longint e;
    int cyc;
    logic [9:0] held;
    e = calc_exp(prev_v, prev_i);
    chk("R2", smp_ready, 1);
    smp_valid = 1'b1; smp_v = v; smp_i = i;
    @(negedge clk);
    smp_valid = 1'b0;
    cyc = 1;
    if (poke) begin
      smp_valid = 1'b1; smp_v = ~v; smp_i = ~i;
      chk("R2", smp_ready, 0);
      repeat (3) @(negedge clk);
      cyc += 3;
      smp_valid = 1'b0;
    end
    while (!duty_done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10", (cyc <= 104) ? 1 : 0, 1);
    chk(tag, duty, e);
    prev_v = v; prev_i = i;
    if (gap) begin
      held = duty;
      @(negedge clk);
      chk("R9", duty_done, 0);
      chk("R9", duty, held);
    end
  endtask

  task automatic set_rand();
    int mode;
    mode = int'($urandom % 3);
    if (mode == 0) begin
      k_sv = 16'(rs(16)); k_si = 16'(rs(16)); k_onv = 16'(rs(16));
      k_oni = 16'(rs(16)); k_offv = 16'(rs(16)); k_offi = 16'(rs(16));
      ofs_ref = rs(28); ofs_on = rs(28); ofs_off = rs(28);
    end else if (mode == 1) begin
      k_sv = 16'(rs(8)); k_si = 16'(rs(8)); k_onv = 16'(rs(8));
      k_oni = 16'(rs(8)); k_offv = 16'(rs(8)); k_offi = 16'(rs(8));
      ofs_ref = rs(20); ofs_on = rs(20); ofs_off = rs(20);
    end else begin
      k_sv = 16'(rs(6)); k_si = 16'(rs(6)); k_onv = 16'(rs(6));
      k_oni = 16'(rs(6)); k_offv = 16'(rs(6)); k_offi = 16'(rs(6));
      ofs_ref = rs(18); ofs_off = rs(12);
      ofs_on = -int'($urandom_range(1000, 200000));
    end
    n_blend = 5'($urandom % 32);
    d_star  = 10'($urandom % 1024);
  endtask

  task automatic zero_coefs();
    k_sv = '0; k_si = '0; k_onv = '0; k_oni = '0; k_offv = '0; k_offi = '0;
    ofs_ref = '0; ofs_on = '0; ofs_off = '0; n_blend = '0; d_star = '0;
  endtask

  initial begin
    #1900000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5511));
    repeat (3) @(negedge clk);
    chk("R1", smp_ready, 1);
    chk("R1", duty_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", smp_ready, 1);
    chk("R1", duty, 0);
    chk("R1", duty_done, 0);

    // one-period delay: first result sees zero samples
    zero_coefs();
    k_sv = 16'sd1; ofs_on = -32'sd1000;
    xact(12'd200, 12'd0, "R3", 1'b0, 1'b1);
    chk("R3", duty, 0);
    xact(12'd300, 12'd0, "R3", 1'b0, 1'b0);
    chk("R3", duty, 409);

    zero_coefs();
    ofs_on = -32'sd1000; ofs_ref = -32'sd250;
    xact(12'd7, 12'd9, "R5", 1'b0, 1'b1);
    chk("R5", duty, 512);
    n_blend = 5'd1; d_star = 10'd100;
    xact(12'd1, 12'd2, "R7", 1'b0, 1'b0);
    chk("R7", duty, 306);
    n_blend = 5'd31; d_star = 10'd1023;
    xact(12'd3, 12'd4, "R7", 1'b0, 1'b0);
    chk("R7", duty, 1007);

    ofs_on = 32'sd1000; n_blend = 5'd31; d_star = 10'd0;
    xact(12'd5, 12'd5, "R6", 1'b0, 1'b0);
    chk("R6", duty, 1023);
    ofs_ref = 32'sd250;
    xact(12'd6, 12'd6, "R6", 1'b0, 1'b1);
    chk("R6", duty, 0);
    ofs_on = 32'sd0; ofs_ref = -32'sd250;
    xact(12'd8, 12'd8, "R6", 1'b0, 1'b0);
    chk("R6", duty, 1023);

    ofs_on = -32'sd1000; ofs_ref = 32'sd250; n_blend = 5'd0; d_star = 10'd0;
    xact(12'd9, 12'd9, "R8", 1'b0, 1'b0);
    chk("R8", duty, 0);
    n_blend = 5'd3; d_star = 10'd300;
    xact(12'd10, 12'd10, "R7", 1'b0, 1'b0);
    chk("R7", duty, 97);
    ofs_ref = -32'sd5000; n_blend = 5'd0;
    xact(12'd11, 12'd11, "R8", 1'b0, 1'b1);
    chk("R8", duty, 1023);

    // busy-time offers must not reach the sample store
    zero_coefs();
    k_sv = 16'sd3; k_si = -16'sd2; ofs_on = -32'sd20000;
    xact(12'd1000, 12'd300, "R2", 1'b1, 1'b0);
    xact(12'd50, 12'd60, "R2", 1'b0, 1'b0);

    for (int n = 0; n < 220; n++) begin
      set_rand();
      xact(12'($urandom), 12'($urandom), "R4", ($urandom % 8) == 0, ($urandom % 4) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule